// File: doc/BRIEF.md
# Fixed-Head Disk Controller Command and Status Registers

This block is the register side of a programmed-I/O disk controller. A processor issues I/O commands as a set of three pulse lines plus a two-bit sub-code and a device select. The block holds an 18-bit function/status word, a 21-bit disk address that is loaded and read in a low and a high part, and an 18-bit data buffer. It answers reads on a combinational read-data bus and raises a skip flag and an interrupt request from the status word.

A separate transfer engine moves the data. It reports a busy level. It posts error flags and transfer completion, and it receives a one-cycle start strobe together with the current function code. While the engine is busy, most commands are refused. Each refusal leaves a sticky programming-error flag. The function field is changed by XOR, never loaded. The summary error bit is always derived from the individual error flags and is never stored on its own.

Top module: `disk_pio_regs`

## Requirements
- R1: After synchronous reset the status word, the disk address and the buffer are zero, and io_skip, irq and xfer_start are low.
- R2: Status bit 17 equals the OR of bits 16 to 10 (hardware, address parity, missed transfer, write-check, data parity, write lock, nonexistent disk). Bit 9 (channel timing) and bit 8 (programming error) do not feed it.
- R3: io_skip is high when bit 17 or bit 7 (done) is set. irq is high when, in addition, bit 0 (interrupt enable) is set.
- R4: Device 0, pulse bit 1, sub-code 2 XORs io_wdata[2:0] into status bits 2:0. Bits 2:1 are the function code (0 none, 1 read, 2 write, 3 verify) and are visible on xfer_func.
- R5: While eng_busy is high, these device-0 commands set status bit 8 and have no other effect: every pulse-bit-1 or pulse-bit-2 command, and clear-function (pulse bit 0, sub-code 2). The device-1 clear-status command behaves the same way. Refused reads return zero.
- R6: Device 1, pulse bit 1, sub-code 3 returns the status word on io_rdata. While busy it also sets bit 8 and the returned word already shows it.
- R7: Device 0, pulse bit 2, sub-code 3 puts io_wdata[2:0] into address bits 20:18. If the whole address is then at or above cap_words, bit 10 is set. Sub-code 1 loads address bits 17:0 and sub-code 0 loads the buffer.
- R8: Device 0, pulse bit 1: sub-code 3 returns address bits 20:18 in bits 2:0, with bit 3 set when bit 10 is set. Sub-code 1 returns address bits 17:0 and sub-code 0 returns the buffer.
- R9: Device 1, pulse bit 1, sub-code 2 (clear-status) keeps only status bits 2:0. Clear-function (device 0, pulse bit 0, sub-code 2) clears only bits 2:0.
- R10: Device 0, pulse bit 2, sub-code 2 (start) clears bit 7. If the function code is then nonzero, xfer_start is high for exactly the following cycle.
- R11: Device 0, pulse bit 0, sub-code 1 clears status, address and buffer, even while busy.
- R12: eng_err[7:0] sets status bits 16:9 and eng_done sets bit 7. Both are sticky. Bits 6:3 always read as zero, and with no command and no post the status word holds.
- R13: When several pulse bits arrive in one cycle they act in the order bit 0, bit 1, bit 2. Engine posts apply before all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_pulse | input | 3 | Command pulse bits, sampled each cycle |
| io_sub | input | 2 | Command sub-code |
| io_dev | input | 1 | Device select: 0 main command set, 1 status set |
| io_wdata | input | DATA_W | Data supplied with a command |
| eng_busy | input | 1 | Transfer engine busy |
| eng_err | input | 8 | Engine error posts for status bits 16:9 |
| eng_done | input | 1 | Engine transfer-complete post |
| cap_words | input | ADDR_W+1 | Attached capacity in words |
| io_rdata | output | DATA_W | Combinational read result, zero when nothing is read |
| io_skip | output | 1 | Error or done pending |
| irq | output | 1 | Interrupt request |
| xfer_start | output | 1 | One-cycle start strobe to the engine |
| xfer_func | output | 2 | Current function code |

## Verification
The bench targets the places where ordering inside one cycle matters. A combined clear-function, XOR and start must leave the XOR result and strobe, and a design that evaluated the start before the XOR would stay silent. A read combined with a load of the same register must return the old value. A status read while busy must already show the programming-error bit, and a design that registered the flag first would return a stale word. Other checks set only the channel-timing or programming-error flag and confirm that skip stays low, which catches a summary bit that ORs the wrong span. Other checks load the high address to exactly the capacity and to just below it, which separates `>=` from `>`.

// File: rtl/disk_pio_pkg.sv
package disk_pio_pkg;
   localparam int STAT_W   = 18;
   localparam int ENG_W    = 8;     // posts for bits 16:9
   localparam int SB_ERR   = 17;
   localparam int SB_EHI   = 16;
   localparam int SB_ELO   = 10;
   localparam int SB_NXD   = 10;
   localparam int SB_ENGLO = 9;
   localparam int SB_PGE   = 8;
   localparam int SB_DONE  = 7;
   localparam int SB_ZHI   = 6;
   localparam int SB_ZLO   = 3;
   localparam int FNI_W    = 3;     // function + interrupt enable
   localparam int HI_NXD   = 3;     // nxd position in high-address read

   typedef enum logic [1:0] {
      FN_IDLE   = 2'd0,
      FN_RD     = 2'd1,
      FN_WR     = 2'd2,
      FN_VERIFY = 2'd3
   } xfer_fn_e;

   typedef struct packed {
      logic clr_all;
      logic clr_fn;
      logic xor_fn;
      logic rd_buf;
      logic rd_alo;
      logic rd_ahi;
      logic ld_buf;
      logic ld_alo;
      logic ld_ahi;
      logic go;
      logic clr_sta;
      logic rd_sta;
      logic pge;
   } pio_ops_t;
endpackage

// File: rtl/pio_cmd_decode.sv
module pio_cmd_decode
   import disk_pio_pkg::*;
(
   input  logic [2:0] io_pulse,
   input  logic [1:0] io_sub,
   input  logic       io_dev,
   input  logic       busy,
   output pio_ops_t   ops
);
   logic g0, g1, g2, s1;
   logic cf_raw;

   always_comb begin
      g0     = io_pulse[0] & ~io_dev;
      g1     = io_pulse[1] & ~io_dev;
      g2     = io_pulse[2] & ~io_dev;
      s1     = io_pulse[1] &  io_dev;
      cf_raw = g0 & (io_sub == 2'd2);

      ops         = '0;
      ops.clr_all = g0 & (io_sub == 2'd1);
      ops.clr_fn  = cf_raw & ~busy;
      ops.rd_buf  = g1 & ~busy & (io_sub == 2'd0);
      ops.rd_alo  = g1 & ~busy & (io_sub == 2'd1);
      ops.xor_fn  = g1 & ~busy & (io_sub == 2'd2);
      ops.rd_ahi  = g1 & ~busy & (io_sub == 2'd3);
      ops.ld_buf  = g2 & ~busy & (io_sub == 2'd0);
      ops.ld_alo  = g2 & ~busy & (io_sub == 2'd1);
      ops.go      = g2 & ~busy & (io_sub == 2'd2);
      ops.ld_ahi  = g2 & ~busy & (io_sub == 2'd3);
      ops.clr_sta = s1 & ~busy & (io_sub == 2'd2);
      ops.rd_sta  = s1 & (io_sub == 2'd3);
      ops.pge     = busy & (cf_raw | g1 | g2 | (s1 & io_sub[1]));
   end
endmodule

// File: rtl/pio_addr_buf.sv
module pio_addr_buf #(
   parameter int DATA_W = 18,
   parameter int ADDR_W = 21
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr_all,
   input  logic              ld_buf,
   input  logic              ld_alo,
   input  logic              ld_ahi,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W:0]   cap_words,
   output logic [DATA_W-1:0] buf_s1,
   output logic [ADDR_W-1:0] addr_s1,
   output logic              ned_hit
);
   localparam int HI_W = ADDR_W - DATA_W;

   logic [DATA_W-1:0] buf_q, buf_n;
   logic [ADDR_W-1:0] addr_q, addr_n;

   always_comb begin
      buf_s1  = clr_all ? '0 : buf_q;
      addr_s1 = clr_all ? '0 : addr_q;
      buf_n   = ld_buf ? wr_data : buf_s1;
      addr_n  = addr_s1;
      if (ld_alo) addr_n[DATA_W-1:0]      = wr_data;
      if (ld_ahi) addr_n[ADDR_W-1:DATA_W] = wr_data[HI_W-1:0];
      ned_hit = ld_ahi && ({1'b0, addr_n} >= cap_words);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         buf_q  <= '0;
         addr_q <= '0;
      end else begin
         buf_q  <= buf_n;
         addr_q <= addr_n;
      end
   end
endmodule

// File: rtl/pio_status.sv
module pio_status
   import disk_pio_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              clr_all,
   input  logic              clr_fn,
   input  logic              xor_fn,
   input  logic              clr_sta,
   input  logic              go,
   input  logic              pge,
   input  logic              ned_hit,
   input  logic [FNI_W-1:0]  wr_fn,
   input  logic [ENG_W-1:0]  eng_err,
   input  logic              eng_done,
   output logic [STAT_W-1:0] sta_q,
   output logic [STAT_W-1:0] sta_n,
   output logic              nxd_s1,
   output logic              go_ok
);
   logic [STAT_W-1:0] s;

   always_comb begin
      s = sta_q;
      s[SB_EHI:SB_ENGLO] = s[SB_EHI:SB_ENGLO] | eng_err;
      s[SB_DONE]         = s[SB_DONE] | eng_done;
      // stage: pulse bit 0
      if (clr_all) s = '0;
      if (clr_fn)  s[FNI_W-1:0] = '0;
      // stage: pulse bit 1
      if (xor_fn)  s[FNI_W-1:0] = s[FNI_W-1:0] ^ wr_fn;
      if (clr_sta) s = s & STAT_W'((1 << FNI_W) - 1);
      nxd_s1 = s[SB_NXD];
      // stage: pulse bit 2
      go_ok = go && (xfer_fn_e'(s[2:1]) != FN_IDLE);
      if (go)      s[SB_DONE] = 1'b0;
      if (ned_hit) s[SB_NXD]  = 1'b1;
      if (pge)     s[SB_PGE]  = 1'b1;
      s[SB_ZHI:SB_ZLO] = '0;
      s[SB_ERR]        = |s[SB_EHI:SB_ELO];
      sta_n = s;
   end

   always_ff @(posedge clk) begin
      if (rst) sta_q <= '0;
      else     sta_q <= sta_n;
   end
endmodule

// File: rtl/disk_pio_regs.sv
module disk_pio_regs
   import disk_pio_pkg::*;
#(
   parameter int DATA_W = 18,
   parameter int ADDR_W = 21
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        io_pulse,
   input  logic [1:0]        io_sub,
   input  logic              io_dev,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              eng_busy,
   input  logic [ENG_W-1:0]  eng_err,
   input  logic              eng_done,
   input  logic [ADDR_W:0]   cap_words,
   output logic [DATA_W-1:0] io_rdata,
   output logic              io_skip,
   output logic              irq,
   output logic              xfer_start,
   output logic [1:0]        xfer_func
);
   localparam int HI_W  = ADDR_W - DATA_W;
   localparam int N_SRC = 4;

   if (DATA_W != STAT_W) begin : g_bad_data_w
      $error("DATA_W must match the status word width");
   end
   if (HI_W < 1 || HI_W > HI_NXD) begin : g_bad_addr_w
      $error("ADDR_W must exceed DATA_W by 1 to 3 bits");
   end

   pio_ops_t          ops;
   logic [DATA_W-1:0] buf_s1;
   logic [ADDR_W-1:0] addr_s1;
   logic              ned_hit, nxd_s1, go_ok;
   logic [STAT_W-1:0] sta_q, sta_n;
   logic              start_q;

   pio_cmd_decode u_dec (
      .io_pulse(io_pulse), .io_sub(io_sub), .io_dev(io_dev),
      .busy(eng_busy), .ops(ops)
   );

   pio_addr_buf #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ab (
      .clk(clk), .rst(rst), .clr_all(ops.clr_all),
      .ld_buf(ops.ld_buf), .ld_alo(ops.ld_alo), .ld_ahi(ops.ld_ahi),
      .wr_data(io_wdata), .cap_words(cap_words),
      .buf_s1(buf_s1), .addr_s1(addr_s1), .ned_hit(ned_hit)
   );

   pio_status u_st (
      .clk(clk), .rst(rst), .clr_all(ops.clr_all), .clr_fn(ops.clr_fn),
      .xor_fn(ops.xor_fn), .clr_sta(ops.clr_sta), .go(ops.go),
      .pge(ops.pge), .ned_hit(ned_hit), .wr_fn(io_wdata[FNI_W-1:0]),
      .eng_err(eng_err), .eng_done(eng_done),
      .sta_q(sta_q), .sta_n(sta_n), .nxd_s1(nxd_s1), .go_ok(go_ok)
   );

   // read sources, OR-combined
   logic [DATA_W-1:0] hi_val;
   logic [DATA_W-1:0] src [N_SRC];
   logic [N_SRC-1:0]  sel;
   logic [DATA_W-1:0] acc [N_SRC+1];

   always_comb begin
      hi_val                 = '0;
      hi_val[HI_W-1:0]       = addr_s1[ADDR_W-1:DATA_W];
      hi_val[HI_NXD]         = nxd_s1;
   end

   assign src[0] = buf_s1;
   assign src[1] = addr_s1[DATA_W-1:0];
   assign src[2] = hi_val;
   assign src[3] = sta_n;
   assign sel    = {ops.rd_sta, ops.rd_ahi, ops.rd_alo, ops.rd_buf};
   assign acc[0] = '0;

   for (genvar i = 0; i < N_SRC; i++) begin : g_rd
      assign acc[i+1] = acc[i] | (sel[i] ? src[i] : '0);
   end
   assign io_rdata = acc[N_SRC];

   always_ff @(posedge clk) begin
      if (rst) start_q <= 1'b0;
      else     start_q <= go_ok;
   end

   assign xfer_start = start_q;
   assign xfer_func  = sta_q[2:1];
   assign io_skip    = sta_q[SB_ERR] | sta_q[SB_DONE];
   assign irq        = io_skip & sta_q[0];
endmodule

// File: rtl/disk_pio_regs_chk.sv
module disk_pio_regs_chk #(
   parameter int DATA_W = 18
) (
   input logic        clk,
   input logic        rst,
   input logic [2:0]  io_pulse,
   input logic [1:0]  io_sub,
   input logic        io_dev,
   input logic [2:1]  wd_fn,
   input logic        eng_busy,
   input logic [7:0]  eng_err,
   input logic        eng_done,
   input logic        io_skip,
   input logic        irq,
   input logic        xfer_start,
   input logic [1:0]  xfer_func,
   input logic [DATA_W-1:0] sta_q
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!irq && !io_skip && !xfer_start && sta_q == '0));

   // R2
   err_summary_chk: assert property (@(posedge clk) disable iff (rst)
      sta_q[17] == |sta_q[16:10]);

   // R3
   irq_needs_skip_chk: assert property (@(posedge clk) disable iff (rst)
      irq |-> io_skip);

   // R4
   fn_xor_chk: assert property (@(posedge clk) disable iff (rst)
      (!eng_busy && !io_dev && io_pulse == 3'b010 && io_sub == 2'd2)
      |=> xfer_func == ($past(xfer_func) ^ $past(wd_fn)));

   // R5
   busy_no_fn_change_chk: assert property (@(posedge clk) disable iff (rst)
      (eng_busy && !io_dev && io_pulse == 3'b010) |=> $stable(xfer_func));

   // R5
   busy_no_start_chk: assert property (@(posedge clk) disable iff (rst)
      (eng_busy && !io_dev && io_pulse == 3'b100) |=> !xfer_start);

   // R10
   start_cause_chk: assert property (@(posedge clk) disable iff (rst)
      xfer_start |-> $past(!eng_busy && !io_dev && io_pulse[2] && io_sub == 2'd2));

   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (io_pulse == 3'b000 && eng_err == 8'h00 && !eng_done) |=> $stable(sta_q));
endmodule

bind disk_pio_regs disk_pio_regs_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .io_pulse(io_pulse), .io_sub(io_sub),
   .io_dev(io_dev), .wd_fn(io_wdata[2:1]), .eng_busy(eng_busy),
   .eng_err(eng_err), .eng_done(eng_done), .io_skip(io_skip), .irq(irq),
   .xfer_start(xfer_start), .xfer_func(xfer_func), .sta_q(sta_q)
);

// File: tb/disk_pio_regs_tb.sv
module disk_pio_regs_tb;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  io_pulse = '0;
   logic [1:0]  io_sub = '0;
   logic        io_dev = 1'b0;
   logic [17:0] io_wdata = '0;
   logic        eng_busy = 1'b0;
   logic [7:0]  eng_err = '0;
   logic        eng_done = 1'b0;
   logic [21:0] cap_words = 22'h080000;
   logic [17:0] io_rdata;
   logic        io_skip, irq, xfer_start;
   logic [1:0]  xfer_func;

   int n_cmp = 0;
   int n_bad = 0;

   // reference state
   logic [17:0] m_sta = '0;
   logic [20:0] m_da  = '0;
   logic [17:0] m_buf = '0;
   logic        m_go  = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   disk_pio_regs u_dut (
      .clk(clk), .rst(rst), .io_pulse(io_pulse), .io_sub(io_sub),
      .io_dev(io_dev), .io_wdata(io_wdata), .eng_busy(eng_busy),
      .eng_err(eng_err), .eng_done(eng_done), .cap_words(cap_words),
      .io_rdata(io_rdata), .io_skip(io_skip), .irq(irq),
      .xfer_start(xfer_start), .xfer_func(xfer_func)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic step(input string tag, input logic [2:0] p, input logic [1:0] s,
                       input logic d, input logic [17:0] w, input logic b,
                       input logic [7:0] ee, input logic ed);
      logic [17:0] t, rd, bf;
      logic [20:0] da;
      logic pge, go, rsta, skp;
      @(negedge clk);
      io_pulse = p; io_sub = s; io_dev = d; io_wdata = w;
      eng_busy = b; eng_err = ee; eng_done = ed;
      #1;
      t = m_sta; da = m_da; bf = m_buf;
      rd = '0; pge = 1'b0; go = 1'b0; rsta = 1'b0;
      t[16:9] = t[16:9] | ee;
      t[7]    = t[7] | ed;
      if (!d) begin
         if (p[0]) begin
            if (s == 2'd1) begin t = '0; da = '0; bf = '0; end
            else if (s == 2'd2) begin
               if (b) pge = 1'b1; else t[2:0] = 3'b000;
            end
         end
         if (p[1]) begin
            if (b) pge = 1'b1;
            else case (s)
               2'd0: rd = rd | bf;
               2'd1: rd = rd | da[17:0];
               2'd2: t[2:0] = t[2:0] ^ w[2:0];
               default: rd = rd | {14'b0, t[10], da[20:18]};
            endcase
         end
         if (p[2]) begin
            if (b) pge = 1'b1;
            else case (s)
               2'd0: bf = w;
               2'd1: da[17:0] = w;
               2'd2: begin t[7] = 1'b0; go = (t[2:1] != 2'b00); end
               default: begin
                  da[20:18] = w[2:0];
                  if ({1'b0, da} >= cap_words) t[10] = 1'b1;
               end
            endcase
         end
      end else if (p[1] && s[1]) begin
         if (b) pge = 1'b1;
         else if (s == 2'd2) t = t & 18'h00007;
         if (s == 2'd3) rsta = 1'b1;
      end
      if (pge) t[8] = 1'b1;
      t[6:3] = 4'b0000;
      t[17]  = |t[16:10];
      if (rsta) rd = rd | t;
      check(tag, "io_rdata", 32'(io_rdata), 32'(rd));
      @(posedge clk);
      m_sta = t; m_da = da; m_buf = bf; m_go = go;
      #1;
      skp = m_sta[17] | m_sta[7];
      check(tag, "io_skip", 32'(io_skip), 32'(skp));
      check(tag, "irq", 32'(irq), 32'(skp & m_sta[0]));
      check(tag, "xfer_start", 32'(xfer_start), 32'(m_go));
      check(tag, "xfer_func", 32'(xfer_func), 32'(m_sta[2:1]));
   endtask

   // shorthands: device 0 = main, device 1 = status set
   task automatic idle(input string tag);
      step(tag, 3'b000, 2'd0, 1'b0, '0, 1'b0, '0, 1'b0);
   endtask
   task automatic cmd(input string tag, input logic [2:0] p, input logic [1:0] s,
                      input logic d, input logic [17:0] w, input logic b);
      step(tag, p, s, d, w, b, '0, 1'b0);
   endtask

   initial begin
      #(PERIOD * 100000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;

      // R1 reset state
      idle("R1");
      cmd("R1", 3'b010, 2'd3, 1'b1, '0, 1'b0);
      cmd("R1", 3'b010, 2'd0, 1'b0, '0, 1'b0);

      // R4 function XOR
      cmd("R4", 3'b010, 2'd2, 1'b0, 18'o3, 1'b0);
      cmd("R4", 3'b010, 2'd2, 1'b0, 18'o6, 1'b0);
      cmd("R4", 3'b010, 2'd3, 1'b1, '0, 1'b0);

      // R7 / R8 address loads, capacity boundary
      cmd("R7", 3'b100, 2'd1, 1'b0, 18'h12345, 1'b0);
      cmd("R7", 3'b100, 2'd3, 1'b0, 18'o1, 1'b0);
      cmd("R8", 3'b010, 2'd1, 1'b0, '0, 1'b0);
      cmd("R8", 3'b010, 2'd3, 1'b0, '0, 1'b0);
      cmd("R7", 3'b100, 2'd1, 1'b0, 18'h3ffff, 1'b0);
      cmd("R7", 3'b100, 2'd3, 1'b0, 18'o1, 1'b0);
      cmd("R7", 3'b100, 2'd1, 1'b0, 18'h00000, 1'b0);
      cmd("R7", 3'b100, 2'd3, 1'b0, 18'o2, 1'b0);
      cmd("R8", 3'b010, 2'd3, 1'b0, '0, 1'b0);
      cmd("R2", 3'b010, 2'd3, 1'b1, '0, 1'b0);
      cmd("R7", 3'b100, 2'd0, 1'b0, 18'h2aaaa, 1'b0);
      cmd("R8", 3'b010, 2'd0, 1'b0, '0, 1'b0);

      // R9 clear-status keeps function field
      cmd("R9", 3'b010, 2'd2, 1'b1, '0, 1'b0);
      cmd("R9", 3'b010, 2'd3, 1'b1, '0, 1'b0);

      // R10 start with nonzero function, done post, restart
      cmd("R10", 3'b100, 2'd2, 1'b0, '0, 1'b0);
      step("R12", 3'b000, 2'd0, 1'b0, '0, 1'b0, '0, 1'b1);
      cmd("R3", 3'b010, 2'd3, 1'b1, '0, 1'b0);
      cmd("R10", 3'b100, 2'd2, 1'b0, '0, 1'b0);
      cmd("R9", 3'b001, 2'd2, 1'b0, '0, 1'b0);
      cmd("R10", 3'b100, 2'd2, 1'b0, '0, 1'b0);
      cmd("R4", 3'b010, 2'd2, 1'b0, 18'o5, 1'b0);

      // R5 / R6 busy refusals
      cmd("R5", 3'b100, 2'd0, 1'b0, 18'h11111, 1'b1);
      cmd("R5", 3'b010, 2'd0, 1'b0, '0, 1'b1);
      cmd("R5", 3'b010, 2'd1, 1'b0, '0, 1'b1);
      cmd("R5", 3'b010, 2'd2, 1'b0, 18'o7, 1'b1);
      cmd("R5", 3'b100, 2'd2, 1'b0, '0, 1'b1);
      cmd("R5", 3'b100, 2'd3, 1'b0, 18'o7, 1'b1);
      cmd("R5", 3'b001, 2'd2, 1'b0, '0, 1'b1);
      cmd("R5", 3'b010, 2'd2, 1'b1, '0, 1'b1);
      cmd("R6", 3'b010, 2'd3, 1'b1, '0, 1'b1);
      cmd("R5", 3'b010, 2'd0, 1'b0, '0, 1'b0);

      // R12 / R2 engine posts: channel timing alone does not raise error
      step("R12", 3'b000, 2'd0, 1'b0, '0, 1'b0, 8'h01, 1'b0);
      cmd("R2", 3'b010, 2'd3, 1'b1, '0, 1'b0);
      step("R12", 3'b000, 2'd0, 1'b0, '0, 1'b0, 8'h80, 1'b0);
      cmd("R2", 3'b010, 2'd3, 1'b1, '0, 1'b0);

      // R11 clear-all while busy
      cmd("R11", 3'b001, 2'd1, 1'b0, '0, 1'b1);
      cmd("R11", 3'b010, 2'd3, 1'b1, '0, 1'b0);
      cmd("R11", 3'b010, 2'd1, 1'b0, '0, 1'b0);

      // R13 ordering of combined pulses
      cmd("R13", 3'b010, 2'd2, 1'b0, 18'o3, 1'b0);
      cmd("R13", 3'b111, 2'd2, 1'b0, 18'o4, 1'b0);
      cmd("R13", 3'b100, 2'd1, 1'b0, 18'h0abcd, 1'b0);
      cmd("R13", 3'b110, 2'd1, 1'b0, 18'h01234, 1'b0);
      cmd("R13", 3'b010, 2'd1, 1'b0, '0, 1'b0);
      cmd("R13", 3'b011, 2'd1, 1'b0, '0, 1'b0);

      // mixed traffic against the reference
      for (int i = 0; i < 400; i++) begin
         logic [7:0] ee;
         ee = ($urandom % 16 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
         step("R13", 3'($urandom), 2'($urandom), 1'($urandom % 3 == 0),
              18'($urandom), ($urandom % 4 == 0), ee, ($urandom % 8 == 0));
      end
      idle("R12");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule